// File: doc/BRIEF.md
# Overlapping Window Sample Distributor

This block takes a received sample stream that arrives as several parallel lanes on each clock and turns it into one sample window for each of a set of demodulation cores. Every window is a fixed number of symbol periods long. Each window shares its last two symbol periods with the first two symbol periods of the window of the next core. The last window of a frame likewise shares its tail with the first window of the following frame, so the stream has no gap at frame boundaries.

Each lane feeds its own input shift register. When every lane register holds a complete set of fresh samples, a wide output register is loaded in a single clock. Every place of the output register has its own selection multiplexer. Each place takes either a fresh sample from a fixed lane and position, or a sample carried over from the tail of the previous frame. The output then holds still until the next load, so the cores can read their windows at their own pace. A one-cycle pulse announces each new frame, and a per-core valid flag marks that the windows hold real data.

With package length N symbols, M cores and S samples per symbol, one frame advances the stream by (N-2)·M·S samples. The output register holds ((N-2)·M+2)·S places. This advance must be a whole number of input beats, and a violation is reported when the design is elaborated.

Top module: `ovl_window_distributor`

## Requirements
- R1: While the synchronous active-low reset is applied, frame_valid is 0, every win_valid bit is 0, all of win_data is 0 and in_ready is 0. From the first clock after reset is released, in_ready is 1.
- R2: A beat enters the block only on a cycle with in_valid and in_ready both high. Lane l of in_data sits at bits [l·DW +: DW], and lane 0 is the oldest sample of its beat. Beats offered while in_valid is low have no effect on any later window.
- R3: The first full frame gathered after reset only primes the overlap. It raises neither frame_valid nor win_valid. The second full frame is the first one announced.
- R4: In announced frame f (counting from 1 after reset), sample i of core k equals stream sample f·A − 2·S + k·(N−2)·S + i, where A = (N−2)·M·S. Stream samples are numbered from 0 in acceptance order since reset. Core k's window occupies win_data bits [(k·N·S + i)·DW +: DW].
- R5: The first 2·S samples of core 0 in an announced frame equal the last 2·S samples of core M−1 in the previous announced frame.
- R6: frame_valid is a single-cycle pulse. It is high in the second cycle after the clock edge that accepts the last beat of a frame, and only for frames after the priming frame.
- R7: Once windows are valid, win_data does not change on any cycle in which frame_valid is low.
- R8: All win_valid bits rise together with the first frame_valid pulse and stay high until the next reset.
- R9: in_ready stays high during a load. A beat accepted on the load edge belongs to the next frame and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | LANES·DW | Parallel samples, lane 0 oldest |
| frame_valid | output | 1 | One-cycle pulse when a new frame is loaded |
| win_valid | output | CORES | Per-core flag that the windows hold real data |
| win_data | output | CORES·PKT_SYM·SPS·DW | Windows of all cores, core 0 in the low bits |

## Verification
The output load and the acceptance of the first beat of the next frame fall on the same clock edge whenever the input streams without gaps. This is provoked by holding in_valid high for many frames in a row. The same edge must copy the old lane contents into the output while shifting a new beat into the lanes. The outcome is judged by comparing every window of every later frame against stream indices computed arithmetically, which would expose a beat that was dropped or placed in the wrong frame. Runs with alternating and pseudo-random gaps, and a reset in the middle of a frame, check that partial frames and idle cycles leave the windows untouched.

// File: rtl/ovl_dist_pkg.sv
// Shared sizing helpers for the overlapping window distributor.
// Assumes the overlap between neighbouring windows is two symbol periods.
package ovl_dist_pkg;

    // Samples by which the stream advances on each frame load.
    function automatic int frame_advance(int pkt_sym, int cores, int sps);
        return (pkt_sym - 2) * cores * sps;
    endfunction

    // Samples kept from one frame as the head of the next.
    function automatic int overlap_len(int sps);
        return 2 * sps;
    endfunction

    // Total places of the wide output register.
    function automatic int total_places(int pkt_sym, int cores, int sps);
        return ((pkt_sym - 2) * cores + 2) * sps;
    endfunction

endpackage

// File: rtl/lane_shift.sv
// One input lane's shift register.
// Position 0 holds the oldest sample. A new sample enters at DEPTH-1.
// Assumes shift_en is asserted only for accepted beats.
module lane_shift #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [DW-1:0]         din,
    output logic [DEPTH*DW-1:0]   taps
);

    logic [DW-1:0] stage_q [DEPTH];

    // Shift toward position 0 on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) stage_q[d] <= '0;
        end else if (shift_en) begin
            for (int d = 0; d < DEPTH - 1; d++) stage_q[d] <= stage_q[d+1];
            stage_q[DEPTH-1] <= din;
        end
    end

    for (genvar d = 0; d < DEPTH; d++) begin : g_tap
        assign taps[d*DW +: DW] = stage_q[d];
    end

endmodule

// File: rtl/frame_fill_ctrl.sv
// Counts accepted beats, requests an output load one cycle after a frame
// completes, and marks the first completed frame after reset as priming.
// Assumes BEATS >= 1.
module frame_fill_ctrl #(
    parameter int BEATS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic shift_en,
    output logic load,
    output logic frame_valid,
    output logic win_valid_all
);

    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CW-1:0] fill_q;
    logic          ready_q;
    logic          pend_q;
    logic          primed_q;
    logic          fv_q;
    logic          wv_q;
    logic          accept;
    logic          last_beat;

    assign accept    = in_valid && ready_q;
    assign last_beat = (fill_q == CW'(BEATS - 1));

    // Fill counter, load request, priming and valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q   <= '0;
            ready_q  <= 1'b0;
            pend_q   <= 1'b0;
            primed_q <= 1'b0;
            fv_q     <= 1'b0;
            wv_q     <= 1'b0;
        end else begin
            ready_q <= 1'b1;
            if (accept) fill_q <= last_beat ? '0 : fill_q + 1'b1;
            pend_q <= accept && last_beat;
            fv_q   <= pend_q && primed_q;
            if (pend_q) primed_q <= 1'b1;
            if (pend_q && primed_q) wv_q <= 1'b1;
        end
    end

    assign in_ready      = ready_q;
    assign shift_en      = accept;
    assign load          = pend_q;
    assign frame_valid   = fv_q;
    assign win_valid_all = wv_q;

endmodule

// File: rtl/window_reg.sv
// Wide output register. Each place has its own source multiplexer.
// The head places reload from the tail of the previous frame. The rest
// reload from a fixed lane and position of the input shift registers.
// Assumes ADV == LANES * DEPTH and ADV >= OVL.
module window_reg #(
    parameter int DW    = 8,
    parameter int LANES = 2,
    parameter int DEPTH = 8,
    parameter int ADV   = 16,
    parameter int OVL   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [LANES*DEPTH*DW-1:0]  lane_taps,
    output logic [(ADV+OVL)*DW-1:0]    places
);

    localparam int TOTAL = ADV + OVL;

    for (genvar p = 0; p < TOTAL; p++) begin : g_place
        logic [DW-1:0] src;
        logic [DW-1:0] place_q;

        if (p < OVL) begin : g_carry
            assign src = places[(ADV + p)*DW +: DW];
        end else begin : g_fresh
            localparam int J    = p - OVL;
            localparam int LANE = J % LANES;
            localparam int POS  = J / LANES;
            assign src = lane_taps[(LANE*DEPTH + POS)*DW +: DW];
        end

        // Capture this place's source on a load.
        always_ff @(posedge clk) begin
            if (!rst_n)    place_q <= '0;
            else if (load) place_q <= src;
        end

        assign places[p*DW +: DW] = place_q;
    end

endmodule

// File: rtl/ovl_window_distributor.sv
// Top: splits a multi-lane sample stream into overlapping per-core windows.
// Assumes the frame advance is a whole number of input beats.
module ovl_window_distributor #(
    parameter int LANES   = 2,
    parameter int SPS     = 2,
    parameter int PKT_SYM = 4,
    parameter int CORES   = 4,
    parameter int DW      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [LANES*DW-1:0]               in_data,
    output logic                              frame_valid,
    output logic [CORES-1:0]                  win_valid,
    output logic [CORES*PKT_SYM*SPS*DW-1:0]   win_data
);

    import ovl_dist_pkg::*;

    localparam int ADV   = frame_advance(PKT_SYM, CORES, SPS);
    localparam int OVL   = overlap_len(SPS);
    localparam int TOTAL = total_places(PKT_SYM, CORES, SPS);
    localparam int WIN   = PKT_SYM * SPS;
    localparam int STEP  = (PKT_SYM - 2) * SPS;
    localparam int BEATS = ADV / LANES;

    if ((ADV % LANES) != 0 || PKT_SYM < 3) begin : g_cfg_err
        $error("frame advance must be a multiple of LANES and PKT_SYM > 2");
    end

    logic                       shift_en;
    logic                       load;
    logic                       wv_all;
    logic [LANES*BEATS*DW-1:0]  lane_taps;
    logic [TOTAL*DW-1:0]        places;

    frame_fill_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .shift_en      (shift_en),
        .load          (load),
        .frame_valid   (frame_valid),
        .win_valid_all (wv_all)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_shift #(.DW(DW), .DEPTH(BEATS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .din      (in_data[l*DW +: DW]),
            .taps     (lane_taps[l*BEATS*DW +: BEATS*DW])
        );
    end

    window_reg #(
        .DW(DW), .LANES(LANES), .DEPTH(BEATS), .ADV(ADV), .OVL(OVL)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .lane_taps (lane_taps),
        .places    (places)
    );

    for (genvar k = 0; k < CORES; k++) begin : g_core
        assign win_data[k*WIN*DW +: WIN*DW] = places[k*STEP*DW +: WIN*DW];
        assign win_valid[k]                 = wv_all;
    end

endmodule

// File: rtl/ovl_window_distributor_chk.sv
// Temporal checks on the distributor's outputs, bound to every instance.
module ovl_window_distributor_chk #(
    parameter int CORES = 4,
    parameter int WIN   = 8,
    parameter int STEP  = 4,
    parameter int OVL   = 4,
    parameter int DW    = 8,
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_valid,
    input  logic [CORES-1:0]         win_valid,
    input  logic [CORES*WIN*DW-1:0]  win_data
);

    logic [OVL*DW-1:0] tail_q;
    logic              seen_q;

    // Remember the last core's tail from each announced frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            tail_q <= '0;
        end else if (frame_valid) begin
            seen_q <= 1'b1;
            tail_q <= win_data[((CORES-1)*WIN + STEP)*DW +: OVL*DW];
        end
    end

    // R5
    frame_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && seen_q |-> win_data[0 +: OVL*DW] == tail_q);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && (BEATS > 1) |=> !frame_valid);

    // R7
    hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[0] && !frame_valid |-> $stable(win_data));

    // R8
    valid_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> &win_valid);

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[0] |=> &win_valid);

endmodule

bind ovl_window_distributor ovl_window_distributor_chk #(
    .CORES(CORES), .WIN(PKT_SYM*SPS), .STEP((PKT_SYM-2)*SPS),
    .OVL(2*SPS), .DW(DW), .BEATS(((PKT_SYM-2)*CORES*SPS)/LANES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .win_valid   (win_valid),
    .win_data    (win_data)
);

// File: tb/ovl_window_distributor_test.sv
module ovl_window_distributor_test;

    localparam int P     = 2;
    localparam int S     = 2;
    localparam int N     = 4;
    localparam int M     = 4;
    localparam int DW    = 8;
    localparam int ADV   = (N-2)*M*S;
    localparam int OVL   = 2*S;
    localparam int WIN   = N*S;
    localparam int STEP  = (N-2)*S;
    localparam int BEATS = ADV/P;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [P*DW-1:0]        in_data = '0;
    logic                   frame_valid;
    logic [M-1:0]           win_valid;
    logic [M*WIN*DW-1:0]    win_data;

    int checks = 0;
    int fails  = 0;

    // bench model
    int  fill, beats, frames, seed;
    bit  pend, primed, fv_now, wv_now;
    logic [M*WIN*DW-1:0] snap;
    logic [7:0] lfsr = 8'h5b;

    ovl_window_distributor #(.LANES(P), .SPS(S), .PKT_SYM(N), .CORES(M), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .frame_valid(frame_valid), .win_valid(win_valid),
        .win_data(win_data)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] val(int idx);
        return DW'((idx*29 + seed) % 256);
    endfunction

    function automatic logic [WIN*DW-1:0] exp_win(int fr, int k);
        logic [WIN*DW-1:0] w;
        for (int i = 0; i < WIN; i++) w[i*DW +: DW] = val(fr*ADV - OVL + k*STEP + i);
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(frame_valid == fv_now, "R6", 64'(frame_valid), 64'(fv_now));
        chk(win_valid == {M{wv_now}}, "R8", 64'(win_valid), 64'({M{wv_now}}));
        chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
        if (fv_now) begin
            frames++;
            for (int k = 0; k < M; k++)
                chk(win_data[k*WIN*DW +: WIN*DW] == exp_win(frames, k), "R4",
                    64'(win_data[k*WIN*DW +: WIN*DW]), 64'(exp_win(frames, k)));
            snap = win_data;
        end else if (wv_now) begin
            chk(win_data == snap, "R7", 64'(win_data[63:0]), 64'(snap[63:0]));
        end
    endtask

    // One clock: check at negedge, drive, update model for the coming edge.
    task automatic step(bit v);
        bit nfv;
        @(negedge clk);
        check_outputs();
        in_valid = v;
        if (v) begin
            for (int l = 0; l < P; l++) in_data[l*DW +: DW] = val(beats*P + l);
        end else begin
            in_data = {P{8'hc3}} ^ P*DW'(beats);   // R2 junk while idle
        end
        nfv = pend && primed;
        if (pend) primed = 1;
        if (nfv) wv_now = 1;
        pend = v && (fill == BEATS-1);
        if (v) begin
            fill = (fill == BEATS-1) ? 0 : fill + 1;
            beats++;
        end
        fv_now = nfv;
        @(posedge clk);
    endtask

    task automatic do_reset(int new_seed);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        // R1 cleared state
        chk(frame_valid == 0, "R1", 64'(frame_valid), 0);
        chk(win_valid == 0, "R1", 64'(win_valid), 0);
        chk(win_data == '0, "R1", 64'(win_data[63:0]), 0);
        chk(in_ready == 0, "R1", 64'(in_ready), 0);
        fill = 0; beats = 0; frames = 0; pend = 0; primed = 0;
        fv_now = 0; wv_now = 0; seed = new_seed; snap = '0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(in_ready == 1, "R1", 64'(in_ready), 1);
    endtask

    task automatic run(int n, int mode);
        for (int c = 0; c < n; c++) begin
            bit v;
            case (mode)
                0: v = 1'b1;
                1: v = c[0];
                default: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    v = lfsr[0] | lfsr[2];
                end
            endcase
            step(v);
        end
    endtask

    initial begin
        #(8*100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset(11);
        // R3 priming frame is silent
        run(BEATS, 0);
        run(3, 3'd0 == 3'd1 ? 0 : 1);
        chk(frames == 0, "R3", 64'(frames), 0);
        run(BEATS, 0);
        run(4, 1);
        chk(frames == 1, "R3", 64'(frames), 1);
        // continuous streaming: load edge coincides with accept (R9)
        run(BEATS*8, 0);
        run(4, 1);
        // alternating gaps (R2)
        run(BEATS*2*5, 1);
        // pseudo-random gaps
        run(BEATS*12, 2);
        run(6, 1);
        // reset mid-frame, then restart with a new seed
        run(5, 0);
        do_reset(77);
        run(BEATS*6, 0);
        run(BEATS*6, 2);
        run(5, 1);
        chk(frames >= 5, "R3", 64'(frames), 64'd5);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule